// File: doc/BRIEF.md
# Three-Result Unsigned Adder

This block is a purely combinational unsigned adder that takes two operands of a configurable width and presents three results together: the plain sum, the sum plus one and the sum plus two. All three wrap modulo 2^WIDTH. Address generators, rounding steps and compare-and-select datapaths use it when the following logic must choose between neighbouring sums without waiting for a second carry chain.

Internally a half-adder row first rewrites the operand pair as two new numbers with the same total. This fixes the lowest result bit of both the plain sum and the plus-two sum without any carry. The upper bits of the rewritten pair go through one logarithmic-depth prefix network. Each final prefix node is read two ways: as a plain carry and as a carry with an extra unit injected at the bottom. The plus-one result is then rebuilt from the other two with one inverter and a row of 2-to-1 multiplexers.

Top module: `three_sum_adder`

## Requirements
- R1: `sum0` equals (a + b) mod 2^WIDTH.
- R2: `sum1` equals (a + b + 1) mod 2^WIDTH.
- R3: `sum2` equals (a + b + 2) mod 2^WIDTH.
- R4: The results wrap with no carry-out. With a = b = all ones, sum0 = 2^WIDTH-2, sum1 = 2^WIDTH-1 and sum2 = 0. With a + b = 2^WIDTH-1, sum1 = 0 and sum2 = 1.
- R5: Bit 0 of `sum1` is the complement of bit 0 of `sum0`.
- R6: For every bit i of 1 or more, `sum1[i]` equals `sum0[i]` when `sum0[0]` is 0 and equals `sum2[i]` when `sum0[0]` is 1.
- R7: Bit 0 of `sum0` and bit 0 of `sum2` both equal a[0] XOR b[0].
- R8: The block holds no state. All outputs are valid in the same cycle in which the operands are applied, including right after the system comes out of reset with zero operands (0, 1, 2).
- R9: The results are correct for every WIDTH of 4 or more, including widths where the prefix span WIDTH-1 is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| sum0 | output | WIDTH | a + b, wrapped |
| sum1 | output | WIDTH | a + b + 1, wrapped |
| sum2 | output | WIDTH | a + b + 2, wrapped |

## Verification
The hardest case to reach is the one where the plus-one result must take its upper bits from the plus-two path. This happens only when the lowest sum bit is 1 and a carry ripples through a long run of propagate nodes, for example all-ones plus zero, or alternating patterns that sum to all ones. The vector table places these long propagate runs at full width. A narrow instance is then driven through every operand pair, which reaches each kill/propagate/generate mix at every prefix position. Random operands at the wide width cover what remains.

// File: rtl/three_sum_pkg.sv
package three_sum_pkg;

  // Resolved state of a prefix node.
  typedef enum logic [1:0] {
    NODE_KILL = 2'b00,
    NODE_PROP = 2'b01,
    NODE_GEN  = 2'b10
  } node_kind_e;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;

  // Join a more significant group (hi) with the group just below it (lo).
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.gen  = hi.gen | (hi.prop & lo.gen);
    r.prop = hi.prop & lo.prop;
    return r;
  endfunction

  function automatic node_kind_e gp_kind(gp_t n);
    if (n.gen)       return NODE_GEN;
    else if (n.prop) return NODE_PROP;
    else             return NODE_KILL;
  endfunction

  // Carry for the plain sum: only a generating node yields 1.
  function automatic logic carry_plain(node_kind_e k);
    return (k == NODE_GEN);
  endfunction

  // Carry for the sum plus one: any node that is not killing yields 1.
  function automatic logic carry_inc(node_kind_e k);
    return (k != NODE_KILL);
  endfunction

endpackage

// File: rtl/tsa_ha_row.sv
module tsa_ha_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] x,
  output logic [W-1:0] y
);

  assign x[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign y[i] = a[i] ^ b[i];
    if (i < W - 1) begin : g_up
      assign x[i+1] = a[i] & b[i];
    end
  end

  logic [W-1:0] pair_total;
  logic [W-1:0] op_total;
  assign pair_total = x + y;
  assign op_total   = a + b;

  always_comb begin
    // R1
    ha_total_chk: assert (pair_total == op_total)
      else $error("half-adder row changed the operand total");
  end

endmodule

// File: rtl/tsa_prefix_dual.sv
module tsa_prefix_dual
  import three_sum_pkg::*;
#(
  parameter int M = 15
) (
  input  logic [M-1:0] x,
  input  logic [M-1:0] y,
  output logic [M-1:0] sum_plain,
  output logic [M-1:0] sum_inc
);

  localparam int LVLS = (M > 1) ? $clog2(M) : 0;

  for (genvar lv = 0; lv <= LVLS; lv++) begin : stg
    gp_t [M-1:0] nd;
    if (lv == 0) begin : g_leaf
      for (genvar i = 0; i < M; i++) begin : g_bit
        assign nd[i].gen  = x[i] & y[i];
        assign nd[i].prop = x[i] ^ y[i];
      end
    end else begin : g_tree
      for (genvar i = 0; i < M; i++) begin : g_bit
        if (((i >> (lv - 1)) & 1) == 1) begin : g_join
          localparam int J = ((i >> (lv - 1)) << (lv - 1)) - 1;
          assign nd[i] = gp_merge(stg[lv-1].nd[i], stg[lv-1].nd[J]);
        end else begin : g_pass
          assign nd[i] = stg[lv-1].nd[i];
        end
      end
    end
  end

  logic [M-1:0] c_plain;
  logic [M-1:0] c_inc;
  logic [M-1:0] leaf_p;

  assign c_plain[0] = 1'b0;
  assign c_inc[0]   = 1'b1;

  for (genvar i = 0; i < M; i++) begin : g_out
    assign leaf_p[i] = stg[0].nd[i].prop;
    if (i > 0) begin : g_carry
      node_kind_e kind;
      assign kind       = gp_kind(stg[LVLS].nd[i-1]);
      assign c_plain[i] = carry_plain(kind);
      assign c_inc[i]   = carry_inc(kind);
    end
  end

  assign sum_plain = leaf_p ^ c_plain;
  assign sum_inc   = leaf_p ^ c_inc;

  logic [M-1:0] plain_next;
  assign plain_next = sum_plain + 1'b1;

  always_comb begin
    // R2
    carry_order_chk: assert ((c_plain & ~c_inc) == '0)
      else $error("plain carry set where incremented carry is clear");
    // R3
    inc_step_chk: assert (sum_inc == plain_next)
      else $error("incremented sum is not plain sum plus one");
  end

endmodule

// File: rtl/tsa_mux_row.sv
module tsa_mux_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] s_lo,
  input  logic [W-1:0] s_hi,
  output logic [W-1:0] s_mid
);

  assign s_mid[0] = ~s_lo[0];

  for (genvar i = 1; i < W; i++) begin : g_sel
    assign s_mid[i] = s_lo[0] ? s_hi[i] : s_lo[i];
  end

endmodule

// File: rtl/three_sum_adder.sv
module three_sum_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum0,
  output logic [WIDTH-1:0] sum1,
  output logic [WIDTH-1:0] sum2
);

  localparam int UP = WIDTH - 1;

  logic [WIDTH-1:0] xv;
  logic [WIDTH-1:0] yv;
  logic [UP-1:0]    up_plain;
  logic [UP-1:0]    up_inc;

  tsa_ha_row #(.W(WIDTH)) u_ha (
    .a (a),
    .b (b),
    .x (xv),
    .y (yv)
  );

  tsa_prefix_dual #(.M(UP)) u_pfx (
    .x         (xv[WIDTH-1:1]),
    .y         (yv[WIDTH-1:1]),
    .sum_plain (up_plain),
    .sum_inc   (up_inc)
  );

  assign sum0 = {up_plain, yv[0]};
  assign sum2 = {up_inc, yv[0]};

  tsa_mux_row #(.W(WIDTH)) u_mux (
    .s_lo  (sum0),
    .s_hi  (sum2),
    .s_mid (sum1)
  );

  logic [WIDTH-1:0] ref0;
  logic [WIDTH-1:0] step1;
  logic [WIDTH-1:0] step2;
  assign ref0  = a + b;
  assign step1 = sum0 + 1'b1;
  assign step2 = sum0 + 2'd2;

  always_comb begin
    // R1
    plain_sum_chk: assert (sum0 == ref0)
      else $error("sum0 differs from a+b");
    // R2
    mid_sum_chk: assert (sum1 == step1)
      else $error("sum1 is not sum0 plus one");
    // R3
    top_sum_chk: assert (sum2 == step2)
      else $error("sum2 is not sum0 plus two");
    // R7
    low_bit_chk: assert ((sum0[0] == (a[0] ^ b[0])) && (sum2[0] == sum0[0]))
      else $error("low result bits disagree");
  end

endmodule

// File: tb/three_sum_adder_tb.sv
module three_sum_adder_tb;

  localparam int W  = 16;
  localparam int WS = 4;

  typedef struct packed {
    logic [15:0] va;
    logic [15:0] vb;
    logic [15:0] vsum;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'hFFFE},
    '{16'hFFFF, 16'h0000, 16'hFFFF},
    '{16'h8000, 16'h8000, 16'h0000},
    '{16'h1234, 16'h4321, 16'h5555},
    '{16'h00FF, 16'h0001, 16'h0100},
    '{16'h7FFF, 16'h0001, 16'h8000},
    '{16'hAAAA, 16'h5555, 16'hFFFF},
    '{16'hFFFE, 16'h0001, 16'hFFFF},
    '{16'hABCD, 16'h1111, 16'hBCDE}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [W-1:0]  a, b, s0, s1, s2;
  logic [WS-1:0] a4, b4, t0, t1, t2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  three_sum_adder #(.WIDTH(W)) u_dut (
    .a(a), .b(b), .sum0(s0), .sum1(s1), .sum2(s2)
  );

  three_sum_adder #(.WIDTH(WS)) u_dut_small (
    .a(a4), .b(b4), .sum0(t0), .sum1(t1), .sum2(t2)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h)", tag, act, exp, a, b);
    end
  endtask

  task automatic check_wide();
    logic [W-1:0] e0, e1, e2, mid;
    e0 = a + b;
    e1 = a + b + 16'd1;
    e2 = a + b + 16'd2;
    mid = {(s0[0] ? s2[W-1:1] : s0[W-1:1]), ~s0[0]};
    chk("R1 sum0", s0, e0);
    chk("R2 sum1", s1, e1);
    chk("R3 sum2", s2, e2);
    chk("R5 sum1 bit0", {15'd0, s1[0]}, {15'd0, ~s0[0]});
    chk("R6 sum1 select", s1, mid);
    chk("R7 low bits", {14'd0, s0[0], s2[0]}, {14'd0, a[0] ^ b[0], a[0] ^ b[0]});
  endtask

  task automatic apply(logic [W-1:0] va, logic [W-1:0] vb);
    @(posedge clk);
    a = va;
    b = vb;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; a4 = '0; b4 = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8: state right after reset with zero operands
    chk("R8 reset sum0", s0, 16'h0000);
    chk("R8 reset sum1", s1, 16'h0001);
    chk("R8 reset sum2", s2, 16'h0002);
    rst_n = 1'b1;

    for (int k = 0; k < 10; k++) begin
      apply(VECS[k].va, VECS[k].vb);
      chk("R1 table", s0, VECS[k].vsum);
      check_wide();
    end

    // R4 wrap corners
    apply(16'hFFFF, 16'hFFFF);
    chk("R4 ones sum0", s0, 16'hFFFE);
    chk("R4 ones sum1", s1, 16'hFFFF);
    chk("R4 ones sum2", s2, 16'h0000);
    apply(16'h8000, 16'h7FFF);
    chk("R4 max sum1", s1, 16'h0000);
    chk("R4 max sum2", s2, 16'h0001);
    apply(16'hFFFF, 16'hFFFE);
    chk("R4 near sum0", s0, 16'hFFFD);
    chk("R4 near sum2", s2, 16'hFFFF);

    // R9: exhaustive at the narrow width (prefix span 3)
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        @(posedge clk);
        a4 = ia[WS-1:0];
        b4 = ib[WS-1:0];
        @(negedge clk);
        chk("R9 narrow sum0", {12'd0, t0}, {12'd0, 4'(ia + ib)});
        chk("R9 narrow sum1", {12'd0, t1}, {12'd0, 4'(ia + ib + 1)});
        chk("R9 narrow sum2", {12'd0, t2}, {12'd0, 4'(ia + ib + 2)});
      end
    end

    // Random wide operands
    for (int r = 0; r < 1000; r++) begin
      apply(16'($urandom), 16'($urandom));
      check_wide();
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule